// File: doc/BRIEF.md
# Streaming NAND Hamming ECC Generator

This block sits beside a NAND data path and builds Hamming parity while the page data streams past, one byte per strobe. Each 256-byte half of a sector has two 11-bit accumulators. The first holds the parities of the "set" positions. The second holds the parities of the complementary "clear" positions. The low three bits of each accumulator cover the bit index inside the byte. The upper eight bits cover the byte address inside the half. A later corrector takes the XOR of a stored code with a freshly computed one. For a single flipped bit, the first accumulator's syndrome is then the failing byte address and bit index. The syndromes of the two accumulators are complements of each other.

A mode input selects 256-byte sectors (one accumulator pair) or 512-byte sectors (two pairs, one for each half). The block packs each pair into a 3-byte code and presents it low byte first. Software or a sequencer pulses the synchronous reset before each page. There is no other way to restart the accumulators.

Top module: `nand_ecc_stream`

## Requirements
- R1: In the cycle after `rst` is high, all four accumulators, the byte counter and `code_bytes` read zero. A strobe presented in the same cycle as `rst` is discarded, and the next strobe is treated as byte 0.
- R2: Bit j of a "set" accumulator (j = 0..2) is the XOR of every data bit, over the bytes of its half, whose bit index has bit j equal to 1. Bit 3+k (k = 0..7) is the XOR of all data bits of the bytes whose in-half address has bit k equal to 1.
- R3: The "clear" accumulator holds the same parities taken over the positions where the index or address bit is 0.
- R4: Flipping one data bit at address A, bit B changes the set accumulator by exactly {A, B} (address in bits 10:3, bit index in bits 2:0). The XOR of that change with the change in the clear accumulator is 11'h7FF.
- R5: The counter and accumulators change only on a strobe. Idle cycles leave every output unchanged.
- R6: With `wide_page` = 1, bytes 0..255 of a page go to pair 0 and bytes 256..511 go to pair 1, both at address modulo 256.
- R7: With `wide_page` = 0, every byte goes to pair 0, and pair 1 stays at zero.
- R8: `code_bytes[23:0]` = set0 | (clear0 << 11), and `code_bytes[47:24]` = set1 | (clear1 << 11). Byte 0 is bits 7:0. Bits 23:22 and 47:46 are zero.
- R9: A byte strobed at a rising edge is reflected in the outputs right after that edge.
- R10: The counter wraps: after byte 255 in narrow mode, or after byte 511 in wide mode, the next byte goes to pair 0 at address 0 and keeps accumulating.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high restart of counter and accumulators |
| wide_page | input | 1 | 1: 512-byte sectors, two pairs; 0: 256-byte sectors |
| byte_vld | input | 1 | Byte strobe |
| byte_in | input | 8 | Byte passing on the data path |
| ecc_set0 | output | 11 | Set-position parity, first half |
| ecc_clr0 | output | 11 | Clear-position parity, first half |
| ecc_set1 | output | 11 | Set-position parity, second half |
| ecc_clr1 | output | 11 | Clear-position parity, second half |
| code_bytes | output | 48 | Packed codes, bytes 0..2 for pair 0 and bytes 3..5 for pair 1 |

## Verification
The restart and a byte strobe can arrive in the same cycle. The bench provokes this by asserting `rst` together with a strobe carrying a nonzero byte. The outputs must read all zero afterwards. A following single 0x01 byte must then produce the literal code of a lone bit at address 0, which shows the counter restarted from zero and did not count the dropped byte. The half boundary is also crossed in a single cycle: byte 255 and byte 256 go to different pairs on consecutive strobes. A byte-for-byte scoreboard covers this through the wide-mode page that runs past 511.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    localparam int BYTE_W     = 8;
    localparam int BIT_IDX_W  = $clog2(BYTE_W);
    localparam int HALF_BYTES = 256;
    localparam int ADDR_W     = $clog2(HALF_BYTES);
    localparam int PAR_W      = ADDR_W + BIT_IDX_W;
    localparam int NUM_HALVES = 2;
    localparam int HALF_IDX_W = $clog2(NUM_HALVES);
    localparam int CNT_W      = ADDR_W + HALF_IDX_W;
    localparam int CODE_BYTES = (2 * PAR_W + 7) / 8;
    localparam int CODE_W     = CODE_BYTES * 8;

    typedef logic [PAR_W-1:0]  par_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] data_t;

    typedef struct packed {
        par_t clr;
        par_t set;
    } par_pair_t;

    // Parity contribution of one byte at a given in-half address.
    function automatic par_pair_t byte_contrib(addr_t addr, data_t d);
        par_pair_t r;
        logic      odd;
        r   = '0;
        odd = ^d;
        for (int j = 0; j < BIT_IDX_W; j++) begin
            for (int i = 0; i < BYTE_W; i++) begin
                if (i[j]) r.set[j] = r.set[j] ^ d[i];
                else      r.clr[j] = r.clr[j] ^ d[i];
            end
        end
        for (int k = 0; k < ADDR_W; k++) begin
            r.set[BIT_IDX_W+k] = addr[k] & odd;
            r.clr[BIT_IDX_W+k] = ~addr[k] & odd;
        end
        return r;
    endfunction

    // Packed 3-byte code, byte 0 in the low bits.
    function automatic logic [CODE_W-1:0] pack_code(par_pair_t p);
        logic [CODE_W-1:0] w;
        w = '0;
        w[PAR_W-1:0]       = p.set;
        w[2*PAR_W-1:PAR_W] = p.clr;
        return w;
    endfunction

endpackage

// File: rtl/ecc_byte_counter.sv
module ecc_byte_counter
    import nand_ecc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  step,
    input  logic                  wide_mode,
    output addr_t                 addr,
    output logic [HALF_IDX_W-1:0] half_idx
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        if (wide_mode) cnt_nxt = cnt + CNT_W'(1);
        else           cnt_nxt = {HALF_IDX_W'(0), cnt[ADDR_W-1:0] + ADDR_W'(1)};
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (step) cnt <= cnt_nxt;
    end

    assign addr     = cnt[ADDR_W-1:0];
    assign half_idx = wide_mode ? cnt[CNT_W-1 -: HALF_IDX_W] : '0;

    p_restart_zero_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnt == '0));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(cnt));

    p_advance_r10: assert property (@(posedge clk) disable iff (rst)
        step |=> (addr == $past(addr) + ADDR_W'(1)));

endmodule

// File: rtl/ecc_pair_acc.sv
module ecc_pair_acc
    import nand_ecc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  addr_t     addr,
    input  data_t     data,
    output par_pair_t acc
);

    par_pair_t contrib;

    assign contrib = byte_contrib(addr, data);

    always_ff @(posedge clk) begin
        if (rst)     acc <= '0;
        else if (en) acc <= acc ^ contrib;
    end

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc));

    // Every bit of the pair moves together with the byte's overall parity.
    p_pair_balance_r4: assert property (@(posedge clk) disable iff (rst)
        en |=> (((acc.set ^ $past(acc.set)) ^ (acc.clr ^ $past(acc.clr)))
                == {PAR_W{$past(^data)}}));

endmodule

// File: rtl/nand_ecc_stream.sv
module nand_ecc_stream
    import nand_ecc_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wide_page,
    input  logic                          byte_vld,
    input  logic [7:0]                    byte_in,
    output logic [10:0]                   ecc_set0,
    output logic [10:0]                   ecc_clr0,
    output logic [10:0]                   ecc_set1,
    output logic [10:0]                   ecc_clr1,
    output logic [NUM_HALVES*CODE_W-1:0]  code_bytes
);

    addr_t                 cur_addr;
    logic [HALF_IDX_W-1:0] cur_half;
    par_pair_t             pairs [NUM_HALVES];

    ecc_byte_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .step      (byte_vld),
        .wide_mode (wide_page),
        .addr      (cur_addr),
        .half_idx  (cur_half)
    );

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        logic hit;
        assign hit = byte_vld & (cur_half == HALF_IDX_W'(h));

        ecc_pair_acc u_acc (
            .clk  (clk),
            .rst  (rst),
            .en   (hit),
            .addr (cur_addr),
            .data (byte_in),
            .acc  (pairs[h])
        );

        assign code_bytes[h*CODE_W +: CODE_W] = pack_code(pairs[h]);
    end

    assign ecc_set0 = pairs[0].set;
    assign ecc_clr0 = pairs[0].clr;
    assign ecc_set1 = pairs[1].set;
    assign ecc_clr1 = pairs[1].clr;

    p_restart_outputs_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (code_bytes == '0));

    p_narrow_upper_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !wide_page |=> ($stable(ecc_set1) && $stable(ecc_clr1)));

endmodule

// File: tb/sim_nand_ecc_stream.sv
module sim_nand_ecc_stream;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wide_page = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = '0;
    logic [10:0] ecc_set0, ecc_clr0, ecc_set1, ecc_clr1;
    logic [47:0] code_bytes;

    nand_ecc_stream u0 (
        .clk        (clk),
        .rst        (rst),
        .wide_page  (wide_page),
        .byte_vld   (byte_vld),
        .byte_in    (byte_in),
        .ecc_set0   (ecc_set0),
        .ecc_clr0   (ecc_clr0),
        .ecc_set1   (ecc_set1),
        .ecc_clr1   (ecc_clr1),
        .code_bytes (code_bytes)
    );

    always #(CLK_NS/2) clk = ~clk;

    int cyc = 0;
    int nchk = 0;
    int nfail = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [10:0] s0, c0, s1, c1;
        int          due;
        string       req;
    } exp_t;

    exp_t q[$];

    // Reference model state
    logic [10:0] ms [2];
    logic [10:0] mc [2];
    logic [8:0]  mcnt;
    logic        mwide;

    task automatic model_clear();
        ms[0] = '0; ms[1] = '0; mc[0] = '0; mc[1] = '0; mcnt = '0;
    endtask

    task automatic model_byte(input logic [7:0] d);
        int          h;
        logic [7:0]  a;
        h = mwide ? int'(mcnt[8]) : 0;
        a = mcnt[7:0];
        for (int i = 0; i < 8; i++) begin
            if (d[i]) begin
                for (int j = 0; j < 3; j++) begin
                    if (i[j]) ms[h][j] = ~ms[h][j];
                    else      mc[h][j] = ~mc[h][j];
                end
                for (int k = 0; k < 8; k++) begin
                    if (a[k]) ms[h][3+k] = ~ms[h][3+k];
                    else      mc[h][3+k] = ~mc[h][3+k];
                end
            end
        end
        if (mwide) mcnt = mcnt + 9'd1;
        else       mcnt = {1'b0, mcnt[7:0] + 8'd1};
    endtask

    task automatic push(input string req);
        exp_t e;
        e.s0 = ms[0]; e.c0 = mc[0]; e.s1 = ms[1]; e.c1 = mc[1];
        e.due = cyc + 1;
        e.req = req;
        q.push_back(e);
    endtask

    task automatic check(input string req, input logic [47:0] got, input logic [47:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Monitor: compares every due scoreboard item away from the active edge.
    always @(negedge clk) begin : mon
        exp_t e;
        while (q.size() > 0 && q[0].due <= cyc) begin
            e = q.pop_front();
            check(e.req, {4'b0, ecc_clr1, ecc_set1, ecc_clr0, ecc_set0},
                         {4'b0, e.c1, e.s1, e.c0, e.s0});
            check("R8", code_bytes, {2'b0, e.c1, e.s1, 2'b0, e.c0, e.s0});
        end
    end

    task automatic drive_byte(input logic [7:0] d, input string req);
        @(negedge clk);
        byte_vld = 1'b1;
        byte_in  = d;
        model_byte(d);
        push(req);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_vld = 1'b0;
            byte_in  = 8'h5A;
            push("R5");
        end
    endtask

    task automatic restart(input logic wide, input logic with_strobe);
        @(negedge clk);
        rst       = 1'b1;
        wide_page = wide;
        mwide     = wide;
        byte_vld  = with_strobe;
        byte_in   = 8'hA5;
        model_clear();
        push("R1");
        @(negedge clk);
        rst      = 1'b0;
        byte_vld = 1'b0;
    endtask

    function automatic logic [7:0] gen(input int seed, input int i);
        return 8'((i * 37 + seed * 11 + (i >> 3)) ^ (i << 2));
    endfunction

    task automatic run_page(input int seed, input int flip_at, input int flip_bit);
        logic [7:0] d;
        restart(1'b0, 1'b0);
        for (int i = 0; i < 256; i++) begin
            d = gen(seed, i);
            if (i == flip_at) d = d ^ (8'd1 << flip_bit);
            drive_byte(d, "R2");
        end
        idle(2);
    endtask

    logic [10:0] a_s, a_c, b_s, b_c;
    bit finished = 0;

    initial begin
        model_clear();
        mwide = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", code_bytes, 48'h0);

        // Lone 0x01 at address 0: set=0, clear=all ones (R2, R3, R8)
        restart(1'b0, 1'b0);
        drive_byte(8'h01, "R9");
        idle(1);
        @(negedge clk);
        check("R3", {37'b0, ecc_clr0}, {37'b0, 11'h7FF});
        check("R2", {37'b0, ecc_set0}, 48'h0);
        check("R8", code_bytes, 48'h0000_003F_F800);

        // Lone 0x80 at address 255: set=all ones, clear=0
        restart(1'b0, 1'b0);
        for (int i = 0; i < 255; i++) drive_byte(8'h00, "R2");
        drive_byte(8'h80, "R2");
        idle(1);
        @(negedge clk);
        check("R2", {37'b0, ecc_set0}, {37'b0, 11'h7FF});
        check("R8", code_bytes, 48'h0000_0000_07FF);

        // Restart and strobe in the same cycle: strobe dropped (R1)
        restart(1'b0, 1'b1);
        idle(1);
        drive_byte(8'h01, "R1");
        idle(1);
        @(negedge clk);
        check("R1", code_bytes, 48'h0000_003F_F800);

        // Single-bit flip syndrome (R4)
        run_page(3, -1, 0);
        @(negedge clk);
        a_s = ecc_set0; a_c = ecc_clr0;
        run_page(3, 77, 5);
        @(negedge clk);
        b_s = ecc_set0; b_c = ecc_clr0;
        check("R4", {37'b0, a_s ^ b_s}, {37'b0, 8'd77, 3'd5});
        check("R4", {37'b0, (a_s ^ b_s) ^ (a_c ^ b_c)}, {37'b0, 11'h7FF});

        // Wide mode across the half boundary and past the wrap (R6, R10)
        restart(1'b1, 1'b0);
        for (int i = 0; i < 515; i++) begin
            drive_byte(gen(7, i), (i < 256) ? "R6" : ((i < 512) ? "R6" : "R10"));
            if (i == 100) idle(3);
        end
        idle(2);

        // Narrow mode long run: upper pair idle, address wraps (R7, R10)
        restart(1'b0, 1'b0);
        for (int i = 0; i < 600; i++) drive_byte(gen(9, i), (i < 256) ? "R7" : "R10");
        idle(2);
        @(negedge clk);
        check("R7", {26'b0, ecc_clr1, ecc_set1}, 48'h0);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule